// File: doc/BRIEF.md
# Windowed Activation Throttle Monitor

This block watches the stream of DRAM row-activate commands that a memory controller issues and decides when global activation throttling must be engaged and when it may be released. Each clock cycle carries at most one activate, tagged with the index of the DIMM it targets. A free-running window timer splits time into long sampling windows. A saturating counter for each DIMM tallies that DIMM's activates inside the current window. At the last cycle of every window each tally is compared against a threshold scaled from an 8-bit limit setting.

If any DIMM went over the threshold, a sticky throttle flag is raised on the following cycle. The flag drops only after an unbroken run of clean windows, in which no DIMM went over. The run is long in normal mode and short in debug mode. A debug-mode select also shortens the window, so throttling behaviour can be observed quickly. The flag is a status output that other logic reads and nothing can write. The block also exposes a one-cycle pulse that marks the last cycle of each window. Blocking of commands is left to the consumer of the flag.

The window base length is a parameter. The scale from limit to threshold is derived so that a limit of 168 always equals one activate every two cycles over the whole window. The window multipliers can therefore be shrunk for fast simulation without changing the meaning of the limit.

Top module: `act_throttle_mon`

## Requirements
- R1: A window lasts BASE_CYCLES×NORM_MULT cycles when `dbg_mode` is 0 and BASE_CYCLES×DBG_MULT cycles when it is 1. With the defaults these are 22020096 and 5376 cycles. `win_end_o` is high for exactly the last cycle of each window.
- R2: The threshold is min(`limit_cfg`,168)×S. S is NORM_MULT×BASE_CYCLES/336 in normal mode and DBG_MULT×BASE_CYCLES/336 in debug mode. With the defaults, 168 gives 11010048 in normal mode and 2688 in debug mode.
- R3: `throttle_o` rises in the cycle after a window's last cycle if any DIMM's count for that window is strictly greater than the threshold. The count includes an activate presented in that last cycle. A count equal to the threshold does not raise it.
- R4: Counts are kept per DIMM. `act_valid` with index i adds one to DIMM i only. Activates spread over several DIMMs do not combine against the threshold.
- R5: All counts restart from zero at every window boundary, so activates from one window never count toward the next.
- R6: Once set, `throttle_o` clears in the cycle after the end of the 16th consecutive clean window in normal mode, or the 2nd in debug mode. Between window ends it never changes.
- R7: A window in which some DIMM exceeds the threshold while `throttle_o` is already set restarts the clean-window run from zero.
- R8: Each count saturates at 2^CNT_W−1 instead of wrapping, so a DIMM that is activated in every cycle still exceeds the threshold.
- R9: While `rst_n` is low, `throttle_o` and `win_end_o` are 0. Reset is applied asynchronously and released through a two-stage synchronizer.
- R10: A `limit_cfg` value above 168 behaves exactly as 168.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | One row-activate command this cycle |
| act_dimm | input | DIMM_W | Target DIMM index of the activate |
| limit_cfg | input | 8 | Activation limit setting, 0 to 168 meaningful |
| dbg_mode | input | 1 | 1 selects the short debug window and 2-window release |
| throttle_o | output | 1 | Sticky global throttle flag |
| win_end_o | output | 1 | High during the last cycle of each window |

## Verification
A corrupted per-DIMM count or threshold shows up only as `throttle_o` taking the wrong value in the single cycle after a window ends. Errors therefore surface at window granularity, and the bench compares the flag against a model in every cycle. A faulty window timer shows up at once as a `win_end_o` period that differs from the mode's window length. A broken clean-run counter is only visible when the flag drops one or more windows early or late, so release is checked window by window in both modes. Counts placed exactly at and one above the threshold, a final activate placed on the boundary cycle, and a DIMM activated every cycle tell off-by-one, boundary and wrap faults apart.

// File: rtl/atm_pkg.sv
`timescale 1ns/1ps
package atm_pkg;

  // Limit value that stands for full activation bandwidth.
  localparam int LIMIT_MAX = 168;

  // Full bandwidth is one activate per two cycles: window/336 per limit unit
  // when the window is a multiple of 168*2 cycles.
  localparam int BW_DIVISOR = 336;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_DEBUG  = 1'b1
  } win_mode_e;

  function automatic logic [7:0] clamp_limit(input logic [7:0] raw);
    return (raw > 8'(LIMIT_MAX)) ? 8'(LIMIT_MAX) : raw;
  endfunction

endpackage

// File: rtl/atm_win_timer.sv
`timescale 1ns/1ps
module atm_win_timer #(
  parameter int BASE_CYCLES = 1344,
  parameter int NORM_MULT   = 16384,
  parameter int DBG_MULT    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_mode_i,
  output logic win_end_o
);

  localparam int NORM_LEN = BASE_CYCLES * NORM_MULT;
  localparam int DBG_LEN  = BASE_CYCLES * DBG_MULT;
  localparam int MAX_LEN  = (NORM_LEN > DBG_LEN) ? NORM_LEN : DBG_LEN;
  localparam int TW       = $clog2(MAX_LEN);
  localparam logic [TW-1:0] NORM_LAST = TW'(NORM_LEN - 1);
  localparam logic [TW-1:0] DBG_LAST  = TW'(DBG_LEN - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] last_sel;
  logic          at_end;

  always_comb begin
    last_sel = dbg_mode_i ? DBG_LAST : NORM_LAST;
    at_end   = (cnt_q >= last_sel);
    cnt_d    = at_end ? '0 : (cnt_q + TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign win_end_o = at_end;

  // R1: the window restarts from zero after its last cycle
  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> (cnt_q == '0));

  // R1: the boundary pulse lasts one cycle
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> !at_end);

endmodule

// File: rtl/atm_act_counter.sv
`timescale 1ns/1ps
module atm_act_counter #(
  parameter int CNT_W = 24,
  parameter int THR_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             win_end_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             over_o
);

  localparam int CMP_W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cnt_sat;
  logic             at_max;
  logic             cnt_en;
  logic [CMP_W-1:0] cnt_wide, thr_wide;

  always_comb begin
    at_max   = &cnt_q;
    cnt_sat  = at_max ? cnt_q : (cnt_q + {{(CNT_W-1){1'b0}}, inc_i});
    cnt_wide = {{(CMP_W-CNT_W){1'b0}}, cnt_sat};
    thr_wide = {{(CMP_W-THR_W){1'b0}}, thr_i};
    over_o   = win_end_i && (cnt_wide > thr_wide);
    cnt_en   = inc_i || win_end_i;
    cnt_d    = win_end_i ? '0 : cnt_sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: the tally is empty at the start of every window
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_i |=> (cnt_q == '0));

  // R8: inside a window the tally never goes down (no wrap)
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end_i |=> (cnt_q >= $past(cnt_q)));

  // R4: the tally moves only on its own activate or a boundary
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !win_end_i) |=> $stable(cnt_q));

endmodule

// File: rtl/atm_release_ctrl.sv
`timescale 1ns/1ps
module atm_release_ctrl #(
  parameter int NORM_RUN = 16,
  parameter int DBG_RUN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_mode_i,
  input  logic win_end_i,
  input  logic over_i,
  output logic flag_o
);

  localparam int MAX_RUN = (NORM_RUN > DBG_RUN) ? NORM_RUN : DBG_RUN;
  localparam int RW      = $clog2(MAX_RUN + 1);
  localparam logic [RW-1:0] NORM_NEED = RW'(NORM_RUN);
  localparam logic [RW-1:0] DBG_NEED  = RW'(DBG_RUN);

  logic          flag_q, flag_d;
  logic [RW-1:0] run_q, run_d;
  logic [RW-1:0] run_inc, need;

  always_comb begin
    need    = dbg_mode_i ? DBG_NEED : NORM_NEED;
    run_inc = run_q + RW'(1);
    flag_d  = flag_q;
    run_d   = run_q;
    if (over_i) begin
      flag_d = 1'b1;
      run_d  = '0;
    end else if (flag_q) begin
      if (run_inc >= need) begin
        flag_d = 1'b0;
        run_d  = '0;
      end else begin
        run_d  = run_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      run_q  <= '0;
    end else if (win_end_i) begin
      flag_q <= flag_d;
      run_q  <= run_d;
    end
  end

  assign flag_o = flag_q;

  // R3: a window with an excess sets the flag on the next cycle
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end_i && over_i) |=> flag_q);

  // R3: the flag only rises after a boundary with an excess
  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(win_end_i && over_i));

  // R6: between boundaries the flag does not move
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end_i |=> $stable(flag_q));

  // R6: the flag drops only when the clean run reaches its length
  p_fall_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> ($past(win_end_i) && !$past(over_i) &&
                       (($past(run_q) + 1) >= $past(need))));

  // R7: an excess restarts the clean run
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end_i && over_i) |=> (run_q == '0));

endmodule

// File: rtl/act_throttle_mon.sv
`timescale 1ns/1ps
module act_throttle_mon
  import atm_pkg::*;
#(
  parameter int  NUM_DIMM    = 4,
  parameter int  CNT_W       = 24,
  parameter int  BASE_CYCLES = 1344,
  parameter int  NORM_MULT   = 16384,
  parameter int  DBG_MULT    = 4,
  parameter int  NORM_RUN    = 16,
  parameter int  DBG_RUN     = 2,
  localparam int DIMM_W      = (NUM_DIMM > 1) ? $clog2(NUM_DIMM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  input  logic [DIMM_W-1:0] act_dimm,
  input  logic [7:0]        limit_cfg,
  input  logic              dbg_mode,
  output logic              throttle_o,
  output logic              win_end_o
);

  localparam int SCALE_N   = (NORM_MULT * BASE_CYCLES) / BW_DIVISOR;
  localparam int SCALE_D   = (DBG_MULT * BASE_CYCLES) / BW_DIVISOR;
  localparam int SCALE_MAX = (SCALE_N > SCALE_D) ? SCALE_N : SCALE_D;
  localparam int THR_W     = 8 + $clog2(SCALE_MAX + 1);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  // Threshold scaling
  win_mode_e        mode;
  logic [7:0]       lim_eff;
  logic [THR_W-1:0] scale_sel;
  logic [THR_W-1:0] thr;

  always_comb begin
    mode      = win_mode_e'(dbg_mode);
    lim_eff   = clamp_limit(limit_cfg);
    scale_sel = (mode == MODE_DEBUG) ? THR_W'(SCALE_D) : THR_W'(SCALE_N);
    thr       = THR_W'(lim_eff) * scale_sel;
  end

  // Window timer
  logic win_end;

  atm_win_timer #(
    .BASE_CYCLES(BASE_CYCLES),
    .NORM_MULT  (NORM_MULT),
    .DBG_MULT   (DBG_MULT)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .dbg_mode_i(dbg_mode),
    .win_end_o (win_end)
  );

  // Per-DIMM tallies
  logic [NUM_DIMM-1:0] inc_vec;
  logic [NUM_DIMM-1:0] over_vec;

  for (genvar g = 0; g < NUM_DIMM; g++) begin : g_dimm
    assign inc_vec[g] = act_valid && (act_dimm == DIMM_W'(g));

    atm_act_counter #(
      .CNT_W(CNT_W),
      .THR_W(THR_W)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .inc_i    (inc_vec[g]),
      .win_end_i(win_end),
      .thr_i    (thr),
      .over_o   (over_vec[g])
    );
  end

  logic any_over;
  assign any_over = |over_vec;

  // Engage / release decision
  atm_release_ctrl #(
    .NORM_RUN(NORM_RUN),
    .DBG_RUN (DBG_RUN)
  ) u_rel (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .dbg_mode_i(dbg_mode),
    .win_end_i (win_end),
    .over_i    (any_over),
    .flag_o    (throttle_o)
  );

  assign win_end_o = win_end;

  // R4: one activate reaches at most one tally
  p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(inc_vec));

  // R9: outputs are quiet while the internal reset is held
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_int_n |-> (!throttle_o && !win_end_o));

  // R3: an excess is only reported on a window boundary
  p_over_at_end_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    any_over |-> win_end);

endmodule

// File: tb/tb_act_throttle_mon.sv
`timescale 1ns/1ps
module tb_act_throttle_mon;

  localparam int NDIMM = 4;
  localparam int DW    = 2;
  localparam int BASE  = 336;
  localparam int NM    = 4;
  localparam int DM    = 2;
  localparam int CW    = 10;
  localparam int NRUN  = 16;
  localparam int DRUN  = 2;
  localparam int SC_N  = NM * BASE / 336;
  localparam int SC_D  = DM * BASE / 336;
  localparam int LEN_N = BASE * NM;
  localparam int LEN_D = BASE * DM;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          act_valid = 1'b0;
  logic [DW-1:0] act_dimm = '0;
  logic [7:0]    limit_cfg = 8'd0;
  logic          dbg_mode = 1'b0;
  logic          throttle_o, win_end_o;

  act_throttle_mon #(
    .NUM_DIMM(NDIMM), .CNT_W(CW), .BASE_CYCLES(BASE),
    .NORM_MULT(NM), .DBG_MULT(DM), .NORM_RUN(NRUN), .DBG_RUN(DRUN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_dimm(act_dimm),
    .limit_cfg(limit_cfg), .dbg_mode(dbg_mode),
    .throttle_o(throttle_o), .win_end_o(win_end_o)
  );

  always #2 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int m_cnt[NDIMM];
  bit m_flag = 1'b0;
  int m_run  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      if (nerr < 20) $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int thr_of(input int lim, input bit dbg);
    int l = (lim > 168) ? 168 : lim;
    return l * (dbg ? SC_D : SC_N);
  endfunction

  // Drives one window from its first cycle to its boundary cycle.
  task automatic run_win(input bit dbg, input int lim, input int want[NDIMM],
                         input bit late, input bit chk_len, input string req);
    int  rem[NDIMM];
    int  len = 0;
    int  rr = 0;
    bit  done = 1'b0;
    rem = want;
    while (!done) begin
      bit we;
      int pick;
      @(negedge clk);
      chk(throttle_o === m_flag, req, int'(throttle_o), int'(m_flag));
      dbg_mode  = dbg;
      limit_cfg = 8'(lim);
      #1;
      we   = win_end_o;
      pick = -1;
      for (int k = 0; k < NDIMM; k++) begin
        int idx = (rr + k) % NDIMM;
        if (pick < 0 && rem[idx] > 0 && (!late || rem[idx] > 1 || we)) pick = idx;
      end
      if (pick >= 0) begin
        act_valid = 1'b1;
        act_dimm  = DW'(pick);
        rem[pick]--;
        if (m_cnt[pick] < CMAX) m_cnt[pick]++;
        rr = pick + 1;
      end else begin
        act_valid = 1'b0;
      end
      len++;
      if (we) begin
        bit over = 1'b0;
        for (int d = 0; d < NDIMM; d++) begin
          if (m_cnt[d] > thr_of(lim, dbg)) over = 1'b1;
          m_cnt[d] = 0;
        end
        if (over) begin
          m_flag = 1'b1; m_run = 0;
        end else if (m_flag) begin
          if (m_run + 1 >= (dbg ? DRUN : NRUN)) begin m_flag = 1'b0; m_run = 0; end
          else m_run++;
        end
        if (chk_len) chk(len == (dbg ? LEN_D : LEN_N), "R1 window length", len,
                         dbg ? LEN_D : LEN_N);
        done = 1'b1;
      end
    end
  endtask

  // Sampled after the edge that ends the boundary cycle.
  task automatic flag_is(input bit e, input string req);
    #2;
    chk(throttle_o === e, req, int'(throttle_o), int'(e));
  endtask

  task automatic one(input bit dbg, input int lim, input int d, input int n,
                     input bit late, input string req);
    int w[NDIMM] = '{default: 0};
    w[d] = n;
    run_win(dbg, lim, w, late, 1'b1, req);
  endtask

  task automatic quiet(input bit dbg, input int n, input string req);
    int w[NDIMM] = '{default: 0};
    for (int i = 0; i < n; i++) run_win(dbg, 10, w, 1'b0, 1'b1, req);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog all: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    int z[NDIMM] = '{default: 0};
    int w[NDIMM];
    void'($urandom(32'd20240611));
    for (int d = 0; d < NDIMM; d++) m_cnt[d] = 0;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk(throttle_o === 1'b0, "R9 flag in reset", int'(throttle_o), 0);
    chk(win_end_o === 1'b0, "R9 pulse in reset", int'(win_end_o), 0);
    rst_n = 1'b1;

    // align on a boundary, then R1 in both modes
    run_win(1'b0, 10, z, 1'b0, 1'b0, "R1 sync");
    quiet(1'b0, 2, "R1 normal");
    quiet(1'b1, 2, "R1 debug");

    // R3 / R2: exactly at threshold (debug, limit 10 -> 20) stays clear
    one(1'b1, 10, 1, 20, 1'b0, "R3 equal");
    flag_is(1'b0, "R3 equal to threshold");
    // one over, final activate on the boundary cycle
    one(1'b1, 10, 1, 21, 1'b1, "R3 over");
    flag_is(1'b1, "R3 boundary activate counted");
    // R6 debug release after 2 clean windows
    quiet(1'b1, 1, "R6 debug");
    flag_is(1'b1, "R6 debug after 1 clean");
    quiet(1'b1, 1, "R6 debug");
    flag_is(1'b0, "R6 debug after 2 clean");

    // R4: spread load, each DIMM at threshold
    w = '{20, 20, 20, 20};
    run_win(1'b1, 10, w, 1'b0, 1'b1, "R4");
    flag_is(1'b0, "R4 per-DIMM separation");

    // R5: two windows of 15 each on one DIMM
    one(1'b1, 10, 2, 15, 1'b0, "R5");
    one(1'b1, 10, 2, 15, 1'b0, "R5");
    flag_is(1'b0, "R5 clear at boundary");

    // R10 / R2: limit 200 acts as 168 (debug threshold 336)
    one(1'b1, 200, 2, 336, 1'b0, "R10 at");
    flag_is(1'b0, "R10 clamp at threshold");
    one(1'b1, 200, 2, 337, 1'b0, "R10 over");
    flag_is(1'b1, "R10 clamp over threshold");

    // R7: excess while set restarts the run
    quiet(1'b1, 1, "R7");
    one(1'b1, 10, 0, 30, 1'b0, "R7");
    quiet(1'b1, 1, "R7");
    flag_is(1'b1, "R7 run restarted");
    quiet(1'b1, 1, "R7");
    flag_is(1'b0, "R7 release after restart");

    // R6 / R2 normal: limit 50 -> 200
    one(1'b0, 50, 3, 201, 1'b0, "R6 normal set");
    flag_is(1'b1, "R2 normal threshold");
    quiet(1'b0, 15, "R6 normal");
    flag_is(1'b1, "R6 normal after 15 clean");
    quiet(1'b0, 1, "R6 normal");
    flag_is(1'b0, "R6 normal after 16 clean");

    // R8: every cycle on DIMM 0, count saturates above 672
    one(1'b0, 168, 0, 5000, 1'b0, "R8");
    flag_is(1'b1, "R8 saturation keeps excess");
    quiet(1'b0, 16, "R8 release");

    // random windows
    for (int i = 0; i < 30; i++) begin
      bit dbg = 1'($urandom_range(0, 1));
      int lim = $urandom_range(0, 255);
      int t = thr_of(lim, dbg);
      int cap = (dbg ? LEN_D : LEN_N) / NDIMM;
      for (int d = 0; d < NDIMM; d++) begin
        int v = (t > 3) ? $urandom_range(t - 3, t + 2) : $urandom_range(0, 4);
        if ($urandom_range(0, 2) == 0) v = v / 2;
        w[d] = (v > cap) ? cap : v;
      end
      run_win(dbg, lim, w, 1'($urandom_range(0, 1)), 1'b1, "R3 random");
    end
    flag_is(m_flag, "R6 random end state");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule